// File: doc/BRIEF.md
# Nibble rotate decimal unit

This block carries out a four-bit digit rotation that spans an 8-bit accumulator and one byte of memory. Three nibbles take part: the accumulator's low nibble and the two nibbles of the memory byte. They move one position left or right. The accumulator's high nibble is left as it was. The unit reads the byte, captures it, writes the rotated byte back to the same address and then returns the new accumulator together with a new flag byte.

A controller pulses `start` with the direction, the current accumulator, the current flag byte and the byte address. The unit then owns a simple synchronous memory port for the length of the operation. The memory answers a read in the cycle after `mem_rd`, and it stores the write data on the edge that ends the `mem_wr` cycle. The whole operation always takes a fixed number of cycles, 18 by default. It finishes with a one-cycle `done`, and the results on `acc_out` and `flags_out` hold until the next operation.

Top module: `nibble_rot_unit`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are low, and `acc_out` and `flags_out` are 0x00.
- R2: When `start` is high on a rising edge while `busy` is low, the unit takes in `dir_left`, `acc_in`, `flags_in` and `addr_in` and raises `busy`.
- R3: With `dir_left` = 0 (right), the memory byte M becomes {A[3:0], M[7:4]} and the accumulator becomes {A[7:4], M[3:0]}.
- R4: With `dir_left` = 1 (left), the memory byte M becomes {M[3:0], A[3:0]} and the accumulator becomes {A[7:4], M[7:4]}.
- R5: `acc_out[7:4]` always equals `acc_in[7:4]` of the accepted operation.
- R6: `flags_out[0]` (carry) equals `flags_in[0]`, and `flags_out[4]` (half-carry) and `flags_out[1]` (subtract) are 0.
- R7: From the new accumulator N: `flags_out[7]` = N[7], `flags_out[6]` = (N == 0), `flags_out[2]` = 1 when N has an even number of ones, `flags_out[5]` = N[5], `flags_out[3]` = N[3].
- R8: Each operation makes exactly one one-cycle read and then exactly one one-cycle write, two cycles after the read. Both go to the accepted address, and the two strobes are never high together.
- R9: `done` is high for exactly one cycle, and that cycle is the OP_CYCLES-th cycle (18 by default) counted from the cycle after the accepting edge. `busy` stays high from the accepting edge up to and including the `done` cycle.
- R10: A `start` raised while `busy` is high is ignored. The running operation's results, its address and its timing do not change, and no other byte of memory is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir_left | input | 1 | 1 = rotate left, 0 = rotate right |
| acc_in | input | 8 | Accumulator value before the operation |
| flags_in | input | 8 | Flag byte before the operation |
| addr_in | input | AW | Address of the memory byte |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
Directed cases use the nibble pattern 0x5A/0x3C in both directions, which shows whether each nibble lands in its correct slot and whether the two directions have been swapped. Further directed cases produce a zero accumulator, a negative accumulator and both parities. Carry-in values of 0 and 1, combined with a flag byte of all ones, separate a preserved carry from a forced one and show that half-carry and subtract are cleared. Random accumulators, memory bytes, flags, addresses and directions cover the remaining combinations. One case holds `start` high with a different address and accumulator in the middle of an operation, to show that it is ignored.

// File: rtl/nibble_rot_unit.sv
module nibble_rot_unit #(
  parameter int AW        = 16,
  parameter int OP_CYCLES = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_left,
  input  logic [7:0]    acc_in,
  input  logic [7:0]    flags_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_rdata,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  output logic [7:0]    acc_out,
  output logic [7:0]    flags_out,
  output logic          done,
  output logic          busy
);
  localparam int CW = $clog2(OP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CAPT, S_WRITE, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dir_q;
  logic          cy_q;
  logic [7:0]    acc_q;
  logic [7:0]    mem_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    new_acc;

  assign new_acc   = {acc_q[7:4], dir_q ? mem_q[7:4] : mem_q[3:0]};
  assign mem_wdata = dir_q ? {mem_q[3:0], acc_q[3:0]} : {acc_q[3:0], mem_q[7:4]};
  assign mem_addr  = addr_q;
  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_WRITE);
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      dir_q     <= 1'b0;
      cy_q      <= 1'b0;
      acc_q     <= '0;
      mem_q     <= '0;
      addr_q    <= '0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      if (st != S_IDLE) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_READ;
          cnt    <= CW'(1);
          dir_q  <= dir_left;
          cy_q   <= flags_in[0];
          acc_q  <= acc_in;
          addr_q <= addr_in;
        end
        S_READ:  st <= S_CAPT;
        S_CAPT: begin
          mem_q <= mem_rdata;
          st    <= S_WRITE;
        end
        S_WRITE: begin
          acc_out   <= new_acc;
          flags_out <= {new_acc[7], new_acc == 8'h00, new_acc[5], 1'b0,
                        new_acc[3], ~^new_acc, 1'b0, cy_q};
          st        <= S_WAIT;
        end
        S_WAIT:  if (cnt == CW'(OP_CYCLES - 1)) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_rot_unit_chk.sv
module nibble_rot_unit_chk #(
  parameter int AW        = 16,
  parameter int OP_CYCLES = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    acc_in,
  input logic [7:0]    flags_in,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [7:0]    acc_out,
  input logic [7:0]    flags_out,
  input logic          done,
  input logic          busy
);
  localparam int CW = $clog2(OP_CYCLES + 1);

  logic [CW-1:0] ccnt;
  logic [3:0]    sh_hi;
  logic          sh_cy;
  logic [AW-1:0] sh_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccnt <= '0; sh_hi <= '0; sh_cy <= 1'b0; sh_addr <= '0;
    end else if (start && !busy) begin
      ccnt <= CW'(1); sh_hi <= acc_in[7:4]; sh_cy <= flags_in[0]; sh_addr <= addr_in;
    end else if (busy && !done) begin
      ccnt <= ccnt + 1'b1;
    end
  end

  p_done_time_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> ccnt == CW'(OP_CYCLES));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(mem_addr)));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(mem_rd, 2));
  p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> mem_addr == sh_addr);
  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n) done |-> acc_out[7:4] == sh_hi);
  p_carry_hn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[0] == sh_cy && !flags_out[4] && !flags_out[1]));
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[7] == acc_out[7] && flags_out[6] == (acc_out == 8'h00) &&
              flags_out[5] == acc_out[5] && flags_out[3] == acc_out[3] &&
              flags_out[2] == ($countones(acc_out) % 2 == 0)));
endmodule

bind nibble_rot_unit nibble_rot_unit_chk #(.AW(AW), .OP_CYCLES(OP_CYCLES)) u_chk (.*);

// File: tb/tb_nibble_rot_unit.sv
module tb_nibble_rot_unit;
  localparam int AW = 16;
  localparam int OPC = 18;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_left = 1'b0;
  logic [7:0] acc_in = '0, flags_in = '0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, done, busy;
  logic [7:0] mem_rdata, mem_wdata, acc_out, flags_out;

  logic [7:0] ram [256];
  logic tb_we = 1'b0;
  logic [7:0] tb_wa = '0, tb_wd = '0;
  int rd_tot = 0, wr_tot = 0;
  logic [AW-1:0] wr_addr_last = '0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nibble_rot_unit #(.AW(AW), .OP_CYCLES(OPC)) dut (.*);

  always @(posedge clk) begin
    if (tb_we) ram[tb_wa] <= tb_wd;
    if (mem_rd) begin mem_rdata <= ram[mem_addr[7:0]]; rd_tot <= rd_tot + 1; end
    if (mem_wr) begin ram[mem_addr[7:0]] <= mem_wdata; wr_tot <= wr_tot + 1; wr_addr_last <= mem_addr; end
  end

  function automatic logic [7:0] f_mem(input logic dl, input logic [7:0] a, input logic [7:0] m);
    return dl ? {m[3:0], a[3:0]} : {a[3:0], m[7:4]};
  endfunction
  function automatic logic [7:0] f_acc(input logic dl, input logic [7:0] a, input logic [7:0] m);
    return {a[7:4], dl ? m[7:4] : m[3:0]};
  endfunction
  function automatic logic [7:0] f_flags(input logic [7:0] n, input logic [7:0] fin);
    logic [7:0] r;
    r = 8'h00;
    r[0] = fin[0];
    r[7] = n[7];
    r[6] = (n == 8'h00);
    r[5] = n[5];
    r[3] = n[3];
    r[2] = ($countones(n) % 2 == 0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(posedge clk); #1 tb_we = 1'b0;
  endtask

  task automatic run_op(input logic dl, input logic [7:0] a, input logic [7:0] f,
                        input logic [7:0] ad, input logic [7:0] m, input bit intrude);
    int n, rd0, wr0;
    logic [7:0] other, other_val, en;
    other = ad ^ 8'h55;
    poke(ad, m);
    other_val = ram[other];
    rd0 = rd_tot; wr0 = wr_tot;
    @(negedge clk);
    start = 1'b1; dir_left = dl; acc_in = a; flags_in = f; addr_in = {8'h00, ad};
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    while (!done && n < 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (intrude && n == 2) begin
        start = 1'b1; dir_left = ~dl; acc_in = ~a; flags_in = ~f; addr_in = {8'h00, other};
      end
      if (intrude && n == 12) start = 1'b0;
      if (!done) chk(busy == 1'b1, "R9 busy held", busy, 1);
    end
    start = 1'b0;
    en = f_acc(dl, a, m);
    chk(n == OPC, "R9 done cycle", n, OPC);
    chk(acc_out == en, dl ? "R4 acc" : "R3 acc", acc_out, en);
    chk(acc_out[7:4] == a[7:4], "R5 upper nibble", acc_out[7:4], a[7:4]);
    chk(ram[ad] == f_mem(dl, a, m), dl ? "R4 mem" : "R3 mem", ram[ad], f_mem(dl, a, m));
    chk(flags_out[0] == f[0] && flags_out[4] == 1'b0 && flags_out[1] == 1'b0,
        "R6 carry/H/N", flags_out, f_flags(en, f));
    chk(flags_out == f_flags(en, f), "R7 flags", flags_out, f_flags(en, f));
    chk(rd_tot - rd0 == 1 && wr_tot - wr0 == 1, "R8 one read one write",
        (rd_tot - rd0) * 16 + (wr_tot - wr0), 17);
    chk(wr_addr_last == {8'h00, ad}, "R8 write address", wr_addr_last, ad);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 single done pulse", {done, busy}, 0);
    if (intrude) begin
      chk(ram[other] == other_val, "R10 other byte untouched", ram[other], other_val);
      chk(rd_tot - rd0 == 1 && wr_tot - wr0 == 1, "R10 no extra access",
          (rd_tot - rd0) * 16 + (wr_tot - wr0), 17);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle after reset", {busy, done, mem_rd, mem_wr}, 0);
    chk(acc_out == 8'h00 && flags_out == 8'h00, "R1 results zero", {acc_out, flags_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R1 idle after release", {busy, mem_rd, mem_wr}, 0);

    run_op(1'b0, 8'h5A, 8'h00, 8'h10, 8'h3C, 0);
    run_op(1'b1, 8'h5A, 8'h01, 8'h11, 8'h3C, 0);
    run_op(1'b0, 8'h07, 8'hFF, 8'h12, 8'h00, 0);
    run_op(1'b1, 8'hF0, 8'hFE, 8'h13, 8'h0F, 0);
    run_op(1'b1, 8'h2B, 8'hFF, 8'h14, 8'h8E, 0);
    run_op(1'b0, 8'hA3, 8'h00, 8'h15, 8'hC7, 1);
    for (int k = 0; k < 40; k++)
      run_op($urandom_range(0, 1), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), k % 10 == 3);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule